// File: doc/BRIEF.md
# Secondary Cascaded Interrupt Controller

This block gathers a group of interrupt source lines and reduces them to two request outputs for a primary controller. One output is the normal request and the other is the fast request. Each line passes through a two-flop synchronizer. Software then sets the line for either edge or level sensing, and for either polarity. Detected edges are held in a pending latch until software clears them. A level-mode line reports pending for as long as its active level is present.

Software reaches the controller through a small synchronous register bus. A write takes effect on the clock edge where `bus_wr` is high. A read returns its data one clock after `bus_rd` is sampled high, and `bus_rdata` holds that value until the next read.

The enable mask can be changed in three ways:
- a whole-word load, used for example to install a reduced wake mask and later restore the normal one;
- a write-ones-to-set alias;
- a write-ones-to-clear alias.

A per-line route register sends each enabled pending line to either the normal output or the fast output.

Top module: `sic_cascade`

## Requirements
- R1: After reset, every register reads 0, and both request outputs are low.
- R2: A write to address 0 replaces the whole enable mask. Bus bits at or above NUM_LINES are ignored, and they read back as 0 from every register.
- R3: A write to address 1 sets each enable bit whose data bit is 1 and leaves the other bits unchanged. A read of address 1 returns the current enable mask.
- R4: A write to address 2 clears each enable bit whose data bit is 1 and leaves the other bits unchanged. A read of address 2 returns the current enable mask.
- R5: Take a line with mode bit 1 (address 3) and polarity bit 0 (address 4). A rising edge on its input latches it pending, with a latency of three clocks. It stays pending after the input falls.
- R6: Take a line with mode bit 1 and polarity bit 1. It latches pending on a falling edge. A rising edge does not latch it.
- R7: Take a line with mode bit 0. It is pending while its input is at the active level: high for polarity 0 and low for polarity 1. A clear write does not change that. It stops being pending once the level goes inactive.
- R8: Writing 1 to a bit of address 5 removes that line's latched edge. A latched edge otherwise stays. Suppose a clear and a new edge of the same line land on the same clock. The line is then still pending afterwards. Address 5 reads as 0.
- R9: Address 6 reads the pending lines ANDed with the enable mask. Disabling a line hides its latched edge without losing it. Writes to address 6 have no effect.
- R10: The normal output is high when any enabled pending line has its route bit (address 7) at 0. The fast output is high when any enabled pending line has its route bit at 1.
- R11: The mode, polarity and route registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_LINES | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid one clock after the read strobe |
| irq_out | output | 1 | Normal cascade request |
| fiq_out | output | 1 | Fast cascade request |

## Verification
The bench builds the block with NUM_LINES = 8 and BUS_W = 32. This places 24 bus bits above the implemented lines, so the tests can confirm that writes to those bits are dropped and that reads return zeros there. With only eight lines, the tests can give separate lines to each trigger mode: rising edge, falling edge, active-high level and active-low level. They can also route two lines to different outputs at the same time. The same-cycle collision of a clear write and a new edge is lined up to the exact clock. Its expected result follows from the three-register path from source to pending latch.

// File: rtl/sic_pkg.sv
package sic_pkg;
    typedef enum logic [2:0] {
        REG_EN      = 3'd0,
        REG_EN_SET  = 3'd1,
        REG_EN_CLR  = 3'd2,
        REG_MODE    = 3'd3,
        REG_POL     = 3'd4,
        REG_ACK     = 3'd5,
        REG_STAT    = 3'd6,
        REG_ROUTE   = 3'd7
    } sic_reg_e;
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl  = st_q.s2;
    assign prev = st_q.s3;
endmodule

// File: rtl/sic_capture.sv
module sic_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic [N-1:0] prev,
    input  logic [N-1:0] mode,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] ack,
    output logic [N-1:0] pending
);
    logic [N-1:0] edge_hit;
    logic [N-1:0] latch_d, latch_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign edge_hit[i] = pol[i] ? (prev[i] & ~lvl[i]) : (lvl[i] & ~prev[i]);
        assign pending[i]  = mode[i] ? latch_q[i] : (lvl[i] ^ pol[i]);
    end

    always_comb begin
        latch_d = mode & ((latch_q & ~ack) | edge_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // R8: a latched edge survives unless cleared (while still in edge mode)
    assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(latch_q & ~ack)) & mode & ~latch_q) == '0));
endmodule

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N     = 32,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [N-1:0]     status,
    output logic [N-1:0]     enable,
    output logic [N-1:0]     mode,
    output logic [N-1:0]     pol,
    output logic [N-1:0]     route,
    output logic [N-1:0]     ack,
    output logic [BUS_W-1:0] rdata
);
    typedef struct packed {
        logic [N-1:0]     en;
        logic [N-1:0]     mode;
        logic [N-1:0]     pol;
        logic [N-1:0]     route;
        logic [BUS_W-1:0] rd;
    } regs_t;

    regs_t rg_d, rg_q;
    logic [N-1:0] wbits;

    assign wbits = wdata[N-1:0];

    if (BUS_W > N) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^wdata[BUS_W-1:N];
    end

    function automatic logic [BUS_W-1:0] widen(input logic [N-1:0] v);
        logic [BUS_W-1:0] r;
        r = '0;
        r[N-1:0] = v;
        return r;
    endfunction

    always_comb begin
        rg_d = rg_q;
        ack  = '0;
        if (wr_en) begin
            unique case (sic_reg_e'(addr))
                REG_EN:     rg_d.en    = wbits;
                REG_EN_SET: rg_d.en    = rg_q.en | wbits;
                REG_EN_CLR: rg_d.en    = rg_q.en & ~wbits;
                REG_MODE:   rg_d.mode  = wbits;
                REG_POL:    rg_d.pol   = wbits;
                REG_ACK:    ack        = wbits;
                REG_ROUTE:  rg_d.route = wbits;
                default:    ;
            endcase
        end
        if (rd_en) begin
            unique case (sic_reg_e'(addr))
                REG_EN, REG_EN_SET, REG_EN_CLR: rg_d.rd = widen(rg_q.en);
                REG_MODE:  rg_d.rd = widen(rg_q.mode);
                REG_POL:   rg_d.rd = widen(rg_q.pol);
                REG_ROUTE: rg_d.rd = widen(rg_q.route);
                REG_STAT:  rg_d.rd = widen(status);
                default:   rg_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign enable = rg_q.en;
    assign mode   = rg_q.mode;
    assign pol    = rg_q.pol;
    assign route  = rg_q.route;
    assign rdata  = rg_q.rd;

    assert_direct_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> (enable == $past(wdata[N-1:0])));
    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> (enable == ($past(enable) | $past(wdata[N-1:0]))));
    assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2) |=> (enable == ($past(enable) & ~$past(wdata[N-1:0]))));
endmodule

// File: rtl/sic_cascade.sv
module sic_cascade #(
    parameter int NUM_LINES = 32,
    parameter int BUS_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] src_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [2:0]           bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 irq_out,
    output logic                 fiq_out
);
    localparam int N = NUM_LINES;

    logic [N-1:0] lvl, prev, pending, status;
    logic [N-1:0] enable, mode, pol, route, ack;

    sic_sync #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(src_in), .lvl(lvl), .prev(prev)
    );

    sic_capture #(.N(N)) u_cap (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .prev(prev), .mode(mode),
        .pol(pol), .ack(ack), .pending(pending)
    );

    sic_regs #(.N(N), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .rd_en(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .status(status),
        .enable(enable), .mode(mode), .pol(pol), .route(route),
        .ack(ack), .rdata(bus_rdata)
    );

    assign status  = pending & enable;
    assign irq_out = |(status & ~route);
    assign fiq_out = |(status & route);

    // R9: an empty mask keeps both requests quiet
    assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> (!irq_out && !fiq_out));
    // R10: with nothing routed to the fast path it stays low
    assert_fast_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (route == '0) |-> !fiq_out);
endmodule

// File: tb/tb_sic_cascade.sv
module tb_sic_cascade;
    localparam int NL = 8;
    localparam int BW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] src_in = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic irq_out, fiq_out;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sic_cascade #(.NUM_LINES(NL), .BUS_W(BW)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [BW-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_src(input int line, input logic v);
        @(negedge clk);
        src_in[line] = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [BW-1:0] d;
        check("R1 irq", {31'd0, irq_out}, 0);
        check("R1 fiq", {31'd0, fiq_out}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check($sformatf("R1 reg%0d", a), d, 0);
        end
    endtask

    task automatic t_enable();
        logic [BW-1:0] d;
        wr(0, 32'hA5); rd(0, d); check("R2 load", d, 32'hA5);
        wr(0, 32'hFFFF_FF5A); rd(0, d); check("R2 upper bits", d, 32'h5A);
        wr(0, 32'hA5);
        wr(1, 32'h0A); rd(1, d); check("R3 set", d, 32'hAF);
        wr(2, 32'h21); rd(2, d); check("R4 clr", d, 32'h8E);
        rd(0, d); check("R4 direct view", d, 32'h8E);
    endtask

    task automatic t_rise();
        logic [BW-1:0] d;
        wr(0, 32'hFF); wr(3, 32'h01); wr(4, 32'h00);
        set_src(0, 1'b1);
        rd(6, d); check("R5 rise latched", d, 32'h01);
        check("R10 irq on", {31'd0, irq_out}, 1);
        set_src(0, 1'b0);
        rd(6, d); check("R5 held after fall", d, 32'h01);
        wr(5, 32'h01);
        rd(6, d); check("R8 cleared", d, 0);
        check("R8 irq off", {31'd0, irq_out}, 0);
        rd(5, d); check("R8 ack reads 0", d, 0);
    endtask

    task automatic t_fall();
        logic [BW-1:0] d;
        wr(3, 32'h02); wr(4, 32'h02);
        set_src(1, 1'b1);
        rd(6, d); check("R6 no latch on rise", d, 0);
        set_src(1, 1'b0);
        rd(6, d); check("R6 fall latched", d, 32'h02);
        wr(5, 32'h02);
        rd(6, d); check("R6 cleared", d, 0);
    endtask

    task automatic t_level();
        logic [BW-1:0] d;
        wr(3, 32'h00); wr(4, 32'h04);
        repeat (3) @(negedge clk);
        rd(6, d); check("R7 active low pending", d, 32'h04);
        wr(5, 32'h04);
        rd(6, d); check("R7 clear no effect", d, 32'h04);
        set_src(2, 1'b1);
        rd(6, d); check("R7 low inactive", d, 0);
        set_src(3, 1'b1);
        rd(6, d); check("R7 high active", d, 32'h08);
        set_src(3, 1'b0);
        rd(6, d); check("R7 high released", d, 0);
        set_src(2, 1'b0);
        wr(4, 32'h00);
    endtask

    task automatic t_mask();
        logic [BW-1:0] d;
        wr(3, 32'h01);
        set_src(0, 1'b1);
        set_src(0, 1'b0);
        wr(0, 32'h00);
        rd(6, d); check("R9 hidden", d, 0);
        check("R9 irq hidden", {31'd0, irq_out}, 0);
        wr(0, 32'h01);
        rd(6, d); check("R9 revealed", d, 32'h01);
        wr(6, 32'hFF);
        rd(6, d); check("R9 status write ignored", d, 32'h01);
        wr(5, 32'h01);
        wr(0, 32'hFF);
    endtask

    task automatic t_route();
        logic [BW-1:0] d;
        wr(3, 32'h30); wr(7, 32'h20);
        set_src(4, 1'b1); set_src(5, 1'b1);
        check("R10 irq", {31'd0, irq_out}, 1);
        check("R10 fiq", {31'd0, fiq_out}, 1);
        wr(5, 32'h10);
        check("R10 irq after clear", {31'd0, irq_out}, 0);
        check("R10 fiq stays", {31'd0, fiq_out}, 1);
        wr(5, 32'h20);
        check("R10 fiq after clear", {31'd0, fiq_out}, 0);
        rd(7, d); check("R11 route readback", d, 32'h20);
        rd(3, d); check("R11 mode readback", d, 32'h30);
        wr(4, 32'hC3); rd(4, d); check("R11 pol readback", d, 32'hC3);
        wr(4, 32'h00);
        set_src(4, 1'b0); set_src(5, 1'b0);
        wr(5, 32'hFF);
    endtask

    task automatic t_race();
        logic [BW-1:0] d;
        wr(3, 32'h01); wr(0, 32'h01); wr(7, 32'h00);
        @(negedge clk); src_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h01;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(6, d); check("R8 clear with new edge", d, 32'h01);
        wr(5, 32'h01);
        rd(6, d); check("R8 later clear", d, 0);
        set_src(0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_rise();
        t_fall();
        t_level();
        t_mask();
        t_route();
        t_race();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule